// File: doc/BRIEF.md
# Port Pin Mode and Pull-up Control

This block holds the configuration of a six-pin general-purpose port and turns it, pin by pin, into the signals a pad ring needs. Those signals are a drive enable, the value to drive, a weak pull-up request, and the digital value that software sees when it reads the port. Four register words set the state: pin direction, output latch, analog selection and per-pin pull-up enables. A fifth word holds a single global pull-up kill bit. All five sit behind a small synchronous register bus. Writes take effect on the clock edge. Reads are combinational.

Selecting a pin as analog blanks only its digital input path, so an output pin that is also analog-selected keeps driving its latch. Pull-ups are withdrawn by hardware whenever a pin drives. Pin 3 can be configured by a static input as an active-low external reset input. In that mode its digital read is blanked and a reset request is produced from the pad. Pin 3 is input-only, and its pull-up follows the reset-mode input alone, with no register control. A read of the latch address returns the pin read value. A read-modify-write of the latch therefore works from what the pins show.

Top module: `gpio_pin_ctl`

## Requirements
- R1: After reset the direction word reads 0x3F (all inputs), the analog word reads 0x3F, the latch is 0, the pull-up enable word reads 0x37, and the global pull-up kill bit (address 4, bit 0) reads 1. No pin is driven.
- R2: Address 0 is the direction word (bit=1 means input). For pins other than 3, `pad_oe[i]` equals the inverse of direction bit i. Pin 3 never drives, and its direction bit always reads 1.
- R3: Address 1 writes the latch. `pad_out` always equals the latch, whatever the analog word holds.
- R4: Address 2 is the analog word. `pin_rd[i]` is `pad_in[i]` when analog bit i is 0, and 0 when it is 1.
- R5: While `cfg_rst_pin` is 1, `pin_rd[3]` reads 0 and `ext_rst_req` equals the inverse of `pad_in[3]`. While it is 0, `ext_rst_req` is 0.
- R6: For pins other than 3, `pad_pu[i]` is 1 only when pull-up enable bit i (address 3) is 1, the global kill bit is 0 and the pin is an input.
- R7: `pad_pu[3]` equals `cfg_rst_pin`. Address 3 bit 3 always reads 0, and writes to it have no effect.
- R8: While the global kill bit is 1, no pull-up is active on pins other than 3.
- R9: A read of address 1 returns `pin_rd`, not the latch. An output pin that is analog-selected reads back as 0.
- R10: Writes to addresses 5 to 7 change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cfg_rst_pin | input | 1 | Static: pin 3 serves as the external reset input |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Combinational read data |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Per-pin drive enable |
| pad_out | output | 6 | Per-pin drive value |
| pad_pu | output | 6 | Per-pin weak pull-up request |
| pin_rd | output | 6 | Digital read value of the port |
| ext_rst_req | output | 1 | External reset request from pin 3 |

## Verification
Two things can land in the same cycle: a write that changes a pin's direction, and the change in that pin's pull-up and read value. A latch write can also arrive while the pads change under a read of the latch address. The bench applies random register writes together with fresh random pad levels on the same cycles. It then compares every pad output and the read-back of a random address against a model updated only from the writes it issued. Directed steps cover the overlap of analog selection with output drive, and the pin 3 reset mode under both pad levels.

// File: rtl/gpio_pin_ctl_pkg.sv
package gpio_pin_ctl_pkg;
    localparam int PORT_W  = 6;
    localparam int ADDR_W  = 3;
    localparam int RST_PIN = 3;

    localparam logic [ADDR_W-1:0] A_DIR  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LAT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_ANA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PUE  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

    localparam logic [PORT_W-1:0] RST_BIT  = PORT_W'(1) << RST_PIN;
    localparam logic [PORT_W-1:0] PUE_MASK = ~RST_BIT;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] lat;
        logic [PORT_W-1:0] ana;
        logic [PORT_W-1:0] pue;
        logic              pu_kill;
    } cfg_regs_t;
endpackage

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
    import gpio_pin_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    output cfg_regs_t         regs_q
);
    cfg_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_DIR:   regs_d.dir     = wr_data | RST_BIT;
                A_LAT:   regs_d.lat     = wr_data;
                A_ANA:   regs_d.ana     = wr_data;
                A_PUE:   regs_d.pue     = wr_data & PUE_MASK;
                A_CTRL:  regs_d.pu_kill = wr_data[0];
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dir     <= '1;
            regs_q.lat     <= '0;
            regs_q.ana     <= '1;
            regs_q.pue     <= PUE_MASK;
            regs_q.pu_kill <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    AST_RST_DIR_IN: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.dir[RST_PIN]) else $error("AST_RST_DIR_IN");                  // R2
    AST_RST_PUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.pue[RST_PIN]) else $error("AST_RST_PUE_ZERO");               // R7
    AST_BAD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > A_CTRL) |=> $stable(regs_q)) else $error("AST_BAD_ADDR_HOLD"); // R10
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell #(
    parameter bit IS_RST_PIN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_in,
    input  logic lat,
    input  logic ana,
    input  logic pue,
    input  logic pu_kill,
    input  logic rst_mode,
    input  logic pad,
    output logic oe,
    output logic dout,
    output logic pu,
    output logic rd
);
    logic in_blank;

    generate
        if (IS_RST_PIN) begin : g_rst
            always_comb begin
                oe       = 1'b0 & ~dir_in;
                pu       = rst_mode | (1'b0 & pue & ~pu_kill);
                in_blank = ana | rst_mode;
            end
        end else begin : g_io
            always_comb begin
                oe       = ~dir_in;
                pu       = pue & ~pu_kill & dir_in;
                in_blank = ana;
            end
        end
    endgenerate

    always_comb begin
        dout = lat;
        rd   = pad & ~in_blank;
    end

    AST_PU_OFF_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !pu) else $error("AST_PU_OFF_DRIVE");                         // R6
    AST_ANA_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ana |-> !rd) else $error("AST_ANA_READ_ZERO");                        // R4
    AST_OUT_IGNORES_ANA: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (dout == lat)) else $error("AST_OUT_IGNORES_ANA");             // R3
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_pin_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rst_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu,
    output logic [PORT_W-1:0] pin_rd,
    output logic              ext_rst_req
);
    cfg_regs_t regs_q;

    gpio_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .regs_q  (regs_q)
    );

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        gpio_pin_cell #(.IS_RST_PIN(i == RST_PIN)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .dir_in   (regs_q.dir[i]),
            .lat      (regs_q.lat[i]),
            .ana      (regs_q.ana[i]),
            .pue      (regs_q.pue[i]),
            .pu_kill  (regs_q.pu_kill),
            .rst_mode (cfg_rst_pin),
            .pad      (pad_in[i]),
            .oe       (pad_oe[i]),
            .dout     (pad_out[i]),
            .pu       (pad_pu[i]),
            .rd       (pin_rd[i])
        );
    end

    always_comb begin
        ext_rst_req = cfg_rst_pin & ~pad_in[RST_PIN];
        unique case (bus_addr)
            A_DIR:   bus_rdata = regs_q.dir;
            A_LAT:   bus_rdata = pin_rd;
            A_ANA:   bus_rdata = regs_q.ana;
            A_PUE:   bus_rdata = regs_q.pue;
            A_CTRL:  bus_rdata = {{(PORT_W-1){1'b0}}, regs_q.pu_kill};
            default: bus_rdata = '0;
        endcase
    end

    AST_RST_PIN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[RST_PIN]) else $error("AST_RST_PIN_NO_DRIVE");                 // R2
    AST_RST_PIN_PU: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pu[RST_PIN] == cfg_rst_pin) else $error("AST_RST_PIN_PU");         // R7
    AST_KILL_ALL_PU: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.pu_kill |-> ((pad_pu & PUE_MASK) == '0)) else $error("AST_KILL_ALL_PU"); // R8
    AST_RST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_pin |-> !ext_rst_req) else $error("AST_RST_REQ_GATED");       // R5
endmodule

// File: tb/gpio_pin_ctl_bench.sv
module gpio_pin_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_rst_pin = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [5:0] bus_wdata = '0;
    logic [5:0] bus_rdata, pad_in = '0, pad_oe, pad_out, pad_pu, pin_rd;
    logic       ext_rst_req;

    int total = 0, bad = 0;
    logic [5:0] m_dir, m_lat, m_ana, m_pue;
    logic       m_kill;

    always #10 clk = ~clk;

    gpio_pin_ctl u_gpio_pin_ctl (.*);

    function automatic logic [5:0] e_oe();
        return ~m_dir & 6'h37;
    endfunction
    function automatic logic [5:0] e_pu();
        logic [5:0] p = m_pue & {6{~m_kill}} & m_dir & 6'h37;
        p[3] = cfg_rst_pin;
        return p;
    endfunction
    function automatic logic [5:0] e_rd();
        logic [5:0] r = pad_in & ~m_ana;
        if (cfg_rst_pin) r[3] = 1'b0;
        return r;
    endfunction
    function automatic logic [5:0] e_rdata(input logic [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return e_rd();
            3'd2: return m_ana;
            3'd3: return m_pue;
            3'd4: return {5'b0, m_kill};
            default: return 6'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [5:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            3'd0: m_dir = d | 6'h08;
            3'd1: m_lat = d;
            3'd2: m_ana = d;
            3'd3: m_pue = d & 6'h37;
            3'd4: m_kill = d[0];
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a);
        bus_addr = a; #1;
        chk(req, bus_rdata, e_rdata(a));
    endtask

    task automatic chk_all();
        #1;
        chk("R2", pad_oe, e_oe());
        chk("R3", pad_out, m_lat);
        chk("R6", pad_pu, e_pu());
        chk("R4", pin_rd, e_rd());
        chk("R5", {5'b0, ext_rst_req}, {5'b0, cfg_rst_pin & ~pad_in[3]});
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_dir = 6'h3F; m_lat = 6'h00; m_ana = 6'h3F; m_pue = 6'h37; m_kill = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 5; a++) rd_chk("R1", 3'(a));
        chk("R1", pad_oe, 6'h00);
        chk("R1", pad_pu, 6'h00);
        // R4/R3: analog-selected output still drives, reads back 0 (R9)
        pad_in = 6'h3F;
        wr(3'd1, 6'h15);
        wr(3'd0, 6'h08);
        chk_all();
        chk("R3", pad_out, 6'h15);
        rd_chk("R9", 3'd1);
        chk("R9", bus_rdata, 6'h00);
        wr(3'd2, 6'h00);
        pad_in = 6'h15;
        rd_chk("R9", 3'd1);
        chk("R9", bus_rdata, 6'h15);
        // R8 global kill then release with inputs
        wr(3'd0, 6'h3F);
        chk("R8", pad_pu & 6'h37, 6'h00);
        wr(3'd4, 6'h00);
        chk_all();
        chk("R6", pad_pu, 6'h37);
        // R7 pin3 pull-up bit not writable
        wr(3'd3, 6'h3F);
        rd_chk("R7", 3'd3);
        chk("R7", bus_rdata, 6'h37);
        chk("R7", {5'b0, pad_pu[3]}, 6'h00);
        // R5 reset mode under both pad levels
        @(negedge clk);
        cfg_rst_pin = 1'b1; pad_in = 6'h08;
        chk_all();
        chk("R7", {5'b0, pad_pu[3]}, 6'h01);
        pad_in = 6'h00;
        chk_all();
        chk("R5", {5'b0, ext_rst_req}, 6'h01);
        cfg_rst_pin = 1'b0;
        // R2 pin3 direction stays input
        wr(3'd0, 6'h00);
        rd_chk("R2", 3'd0);
        chk("R2", bus_rdata, 6'h08);
        // R10 unmapped writes
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 6'h2A);
            rd_chk("R10", 3'(a));
        end
        for (int a = 0; a < 5; a++) rd_chk("R10", 3'(a));
        // random phase
        for (int k = 0; k < 400; k++) begin
            wr(3'($urandom_range(0, 7)), 6'($urandom()));
            pad_in = 6'($urandom());
            if ($urandom_range(0, 9) == 0) cfg_rst_pin = ~cfg_rst_pin;
            chk_all();
            rd_chk("R9", 3'($urandom_range(0, 7)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule